// File: doc/BRIEF.md
# Dual-Bank Latched Bus Exchanger

This block links one narrow data port, A, to two data ports of the same width, 1B and 2B, through level-sensitive storage latches. Data moving toward A is captured per B bank in its own latch, and a select input decides which of the two captured words is presented on A. Data moving away from A is captured twice, into one latch per B bank. Each bank has its own capture enable, so one bank can be refreshed while the other keeps its word. It is meant for folding two buses onto one, or spreading one bus over two. Typical uses are address/data sharing and interleaving two memory banks.

Every bidirectional pin is split into an input value, an output value and an output-enable flag. The surrounding logic, or a bench, resolves the real bus from these three signals. Each of the three ports has its own active-low drive-disable input. The two B banks can be driven in any combination: neither, one or both.

Top module: `mlx_exchanger`

## Requirements
- R1: While `cap_b1` is high, the 1B return latch follows `b1_in`; with `pick_b1` = 1 and A enabled, `a_out` equals `b1_in`.
- R2: After `cap_b1` goes low, the 1B return latch keeps the word present just before the fall, however `b1_in` changes, until `cap_b1` is high again.
- R3: `cap_b2` controls the 2B return latch in the same way (transparent while high, holding while low); with `pick_b1` = 0, `a_out` shows that latch.
- R4: `pick_b1` = 1 routes the 1B return latch to `a_out` and `pick_b1` = 0 routes the 2B return latch; changing `pick_b1` alone never changes either stored word.
- R5: While `cap_a1` is high, `b1_out` follows `a_in`; once it is low, `b1_out` holds the last word captured.
- R6: `cap_a2` controls `b2_out` from `a_in` in the same way, independently of `cap_a1`: one B bank can capture while the other holds.
- R7: The output-enable flags are active-high copies of the negated disable inputs: `a_oe` = !`a_dis_n`, `b1_oe` = !`b1_dis_n`, `b2_oe` = !`b2_dis_n`. All eight combinations are legal.
- R8: Disabling and re-enabling a port never alters the stored words. A port that is re-enabled shows the word it held before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 12 | Value seen on the A bus |
| a_out | output | 12 | Value the block drives on A |
| a_oe | output | 1 | High when the block drives A |
| b1_in | input | 12 | Value seen on the 1B bus |
| b1_out | output | 12 | Value the block drives on 1B |
| b1_oe | output | 1 | High when the block drives 1B |
| b2_in | input | 12 | Value seen on the 2B bus |
| b2_out | output | 12 | Value the block drives on 2B |
| b2_oe | output | 1 | High when the block drives 2B |
| cap_b1 | input | 1 | Transparent-high enable, 1B-to-A latch |
| cap_b2 | input | 1 | Transparent-high enable, 2B-to-A latch |
| cap_a1 | input | 1 | Transparent-high enable, A-to-1B latch |
| cap_a2 | input | 1 | Transparent-high enable, A-to-2B latch |
| pick_b1 | input | 1 | 1 selects the 1B-side latch onto A, 0 the 2B-side latch |
| a_dis_n | input | 1 | Active-low enable for A (low = block drives) |
| b1_dis_n | input | 1 | Active-low enable for 1B (low = block drives) |
| b2_dis_n | input | 1 | Active-low enable for 2B (low = block drives) |

## Verification
The pass-through assertions assume that the port inputs carry values that are settled and known whenever a capture enable is high. They also assume that the block is never asked to pass a word through a port it is itself driving at that moment, which would close a loop through two open latches. The stimulus keeps to these limits. It drives every input from an initialised value, and it drives a bus only while that port's disable input is high. A contention monitor reports any cycle in which the block and the bench drive the same port. Capture enables toward a port are lowered before that port is handed to the block.

// File: rtl/mlx_pkg.sv
package mlx_pkg;
   // Default port width of the exchanger
   localparam int unsigned MLX_W = 12;
   // Number of B-side banks
   localparam int unsigned MLX_BANKS = 2;
   // Return-path select encoding: 1 picks bank 0 (1B), 0 picks bank 1 (2B)
   typedef enum logic {
      PICK_BANK1 = 1'b0,
      PICK_BANK0 = 1'b1
   } mlx_pick_e;
endpackage

// File: rtl/mlx_latch.sv
module mlx_latch #(
   parameter int unsigned W = 12
) (
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("mlx_latch: W must be at least 1");
   end

   logic [W-1:0] q_r;

   // Transparent while en is high, holds when en is low
   always_latch begin
      if (en) q_r = d;
   end

   assign q = q_r;
endmodule

// File: rtl/mlx_ret_mux.sv
module mlx_ret_mux #(
   parameter int unsigned W = 12
) (
   input  mlx_pkg::mlx_pick_e pick,
   input  logic [W-1:0]       bank0_q,
   input  logic [W-1:0]       bank1_q,
   output logic [W-1:0]       y
);
   if (W < 1) begin : g_bad_w
      $error("mlx_ret_mux: W must be at least 1");
   end

   always_comb begin
      unique case (pick)
         mlx_pkg::PICK_BANK0: y = bank0_q;
         mlx_pkg::PICK_BANK1: y = bank1_q;
         default:             y = bank1_q;
      endcase
   end
endmodule

// File: rtl/mlx_exchanger.sv
module mlx_exchanger #(
   parameter int unsigned W = mlx_pkg::MLX_W
) (
   input  logic [W-1:0] a_in,
   output logic [W-1:0] a_out,
   output logic         a_oe,
   input  logic [W-1:0] b1_in,
   output logic [W-1:0] b1_out,
   output logic         b1_oe,
   input  logic [W-1:0] b2_in,
   output logic [W-1:0] b2_out,
   output logic         b2_oe,
   input  logic         cap_b1,
   input  logic         cap_b2,
   input  logic         cap_a1,
   input  logic         cap_a2,
   input  logic         pick_b1,
   input  logic         a_dis_n,
   input  logic         b1_dis_n,
   input  logic         b2_dis_n
);
   localparam int unsigned NB = mlx_pkg::MLX_BANKS;

   if (W < 1) begin : g_bad_w
      $error("mlx_exchanger: W must be at least 1");
   end
   if (NB != 2) begin : g_bad_nb
      $error("mlx_exchanger: exactly two B banks are supported");
   end

   // Per-bank views of the B side
   logic [W-1:0] b_in_v  [NB];
   logic [W-1:0] ret_q   [NB];
   logic [W-1:0] fwd_q   [NB];
   logic         ret_en  [NB];
   logic         fwd_en  [NB];
   logic         b_dis_v [NB];

   assign b_in_v[0]  = b1_in;
   assign b_in_v[1]  = b2_in;
   assign ret_en[0]  = cap_b1;
   assign ret_en[1]  = cap_b2;
   assign fwd_en[0]  = cap_a1;
   assign fwd_en[1]  = cap_a2;
   assign b_dis_v[0] = b1_dis_n;
   assign b_dis_v[1] = b2_dis_n;

   logic b_oe_v [NB];

   for (genvar k = 0; k < NB; k++) begin : g_bank
      // B-to-A storage for this bank
      mlx_latch #(.W(W)) u_ret (
         .en (ret_en[k]),
         .d  (b_in_v[k]),
         .q  (ret_q[k])
      );
      // A-to-B storage for this bank
      mlx_latch #(.W(W)) u_fwd (
         .en (fwd_en[k]),
         .d  (a_in),
         .q  (fwd_q[k])
      );
      assign b_oe_v[k] = ~b_dis_v[k];
   end

   mlx_pkg::mlx_pick_e pick_e;
   assign pick_e = pick_b1 ? mlx_pkg::PICK_BANK0 : mlx_pkg::PICK_BANK1;

   mlx_ret_mux #(.W(W)) u_mux (
      .pick    (pick_e),
      .bank0_q (ret_q[0]),
      .bank1_q (ret_q[1]),
      .y       (a_out)
   );

   assign a_oe   = ~a_dis_n;
   assign b1_out = fwd_q[0];
   assign b2_out = fwd_q[1];
   assign b1_oe  = b_oe_v[0];
   assign b2_oe  = b_oe_v[1];
endmodule

// File: rtl/mlx_exchanger_chk.sv
module mlx_exchanger_chk #(
   parameter int unsigned W = 12
) (
   input logic [W-1:0] a_in,
   input logic [W-1:0] a_out,
   input logic [W-1:0] b1_in,
   input logic [W-1:0] b1_out,
   input logic [W-1:0] b2_in,
   input logic [W-1:0] b2_out,
   input logic         cap_b1,
   input logic         cap_b2,
   input logic         cap_a1,
   input logic         cap_a2,
   input logic         pick_b1
);
   // The block has no clock: the checks are immediate and compare ports
   // across the latch and select stages once values settle.
   always_comb begin
      if (cap_b1 && pick_b1) begin
         a_r1_pass_1b: assert (a_out == b1_in)
            else $error("R1: open 1B latch not seen on A");
      end
      if (cap_b2 && !pick_b1) begin
         a_r3_pass_2b: assert (a_out == b2_in)
            else $error("R3: open 2B latch not seen on A");
      end
      if (cap_a1) begin
         a_r5_pass_a1: assert (b1_out == a_in)
            else $error("R5: open A-to-1B latch not following A");
      end
      if (cap_a2) begin
         a_r6_pass_a2: assert (b2_out == a_in)
            else $error("R6: open A-to-2B latch not following A");
      end
   end
endmodule

bind mlx_exchanger mlx_exchanger_chk #(.W(W)) u_chk (
   .a_in    (a_in),
   .a_out   (a_out),
   .b1_in   (b1_in),
   .b1_out  (b1_out),
   .b2_in   (b2_in),
   .b2_out  (b2_out),
   .cap_b1  (cap_b1),
   .cap_b2  (cap_b2),
   .cap_a1  (cap_a1),
   .cap_a2  (cap_a2),
   .pick_b1 (pick_b1)
);

// File: tb/mlx_exchanger_tb.sv
`timescale 1ns/1ps
module mlx_exchanger_tb;
   localparam int W = 12;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic [W-1:0] a_drv = '0, b1_drv = '0, b2_drv = '0;
   logic cap_b1 = 1'b1, cap_b2 = 1'b1, cap_a1 = 1'b1, cap_a2 = 1'b1;
   logic pick_b1 = 1'b1;
   logic a_dis_n = 1'b1, b1_dis_n = 1'b1, b2_dis_n = 1'b1;

   logic [W-1:0] a_out, b1_out, b2_out;
   logic a_oe, b1_oe, b2_oe;

   mlx_exchanger #(.W(W)) u_dut (
      .a_in (a_drv), .a_out (a_out), .a_oe (a_oe),
      .b1_in (b1_drv), .b1_out (b1_out), .b1_oe (b1_oe),
      .b2_in (b2_drv), .b2_out (b2_out), .b2_oe (b2_oe),
      .cap_b1 (cap_b1), .cap_b2 (cap_b2), .cap_a1 (cap_a1), .cap_a2 (cap_a2),
      .pick_b1 (pick_b1),
      .a_dis_n (a_dis_n), .b1_dis_n (b1_dis_n), .b2_dis_n (b2_dis_n)
   );

   // Bus resolution: block value when it drives, bench value otherwise.
   // The bench drives a port only while it holds that port's disable high.
   wire [W-1:0] a_bus  = a_oe  ? a_out  : a_drv;
   wire [W-1:0] b1_bus = b1_oe ? b1_out : b1_drv;
   wire [W-1:0] b2_bus = b2_oe ? b2_out : b2_drv;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int cyc = 0;

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Contention monitor and watchdog
   always @(posedge clk) begin
      if (!done) begin
         cyc++;
         checks++;
         if ((a_oe && a_dis_n) || (b1_oe && b1_dis_n) || (b2_oe && b2_dis_n)) begin
            errors++;
            $display("FAIL R7 contention: actual oe %b%b%b expected bench-only drive on ports disabled %b%b%b",
                     a_oe, b1_oe, b2_oe, a_dis_n, b1_dis_n, b2_dis_n);
         end
         if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected at most 20000", cyc);
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   // Apply inputs just after a rising edge; checks follow 2 ns later
   task automatic step();
      @(posedge clk);
      #5;
   endtask
   task automatic settle();
      #2;
   endtask

   task automatic t_init();
      step();   // all latches open with zero inputs
      cap_b1 = 0; cap_b2 = 0; cap_a1 = 0; cap_a2 = 0;
      step();
      a_dis_n = 0; b1_dis_n = 0; b2_dis_n = 0; pick_b1 = 1;
      settle();
      chk("R1 reset A", a_bus, '0);
      chk("R5 reset 1B", b1_bus, '0);
      chk("R6 reset 2B", b2_bus, '0);
      chk("R7 reset oe", {9'd0, a_oe, b1_oe, b2_oe}, 12'h007);
      step();
      a_dis_n = 1; b1_dis_n = 1; b2_dis_n = 1;
   endtask

   task automatic t_ret_1b();
      step();
      a_dis_n = 0; pick_b1 = 1; cap_b1 = 1; b1_drv = 12'hA5C;
      settle(); chk("R1 follow", a_bus, 12'hA5C);
      step(); b1_drv = 12'h123;
      settle(); chk("R1 follow2", a_bus, 12'h123);
      step(); cap_b1 = 0;
      step(); b1_drv = 12'hFFF;
      settle(); chk("R2 hold", a_bus, 12'h123);
      step(); b1_drv = 12'h000;
      settle(); chk("R2 hold2", a_bus, 12'h123);
      step(); cap_b1 = 1;
      settle(); chk("R2 reopen", a_bus, 12'h000);
      step(); cap_b1 = 0; a_dis_n = 1;
   endtask

   task automatic t_ret_2b();
      step();
      a_dis_n = 0; pick_b1 = 0; cap_b2 = 1; b2_drv = 12'h5A3;
      settle(); chk("R3 follow", a_bus, 12'h5A3);
      step(); cap_b2 = 0;
      step(); b2_drv = 12'hE01;
      settle(); chk("R3 hold", a_bus, 12'h5A3);
      step(); cap_b2 = 1;
      settle(); chk("R3 reopen", a_bus, 12'hE01);
      step(); cap_b2 = 0; a_dis_n = 1;
   endtask

   task automatic t_select();
      step();
      cap_b1 = 1; cap_b2 = 1; b1_drv = 12'h111; b2_drv = 12'h222;
      step(); cap_b1 = 0; cap_b2 = 0;
      step(); b1_drv = 12'h000; b2_drv = 12'h000; a_dis_n = 0; pick_b1 = 1;
      settle(); chk("R4 pick 1B", a_bus, 12'h111);
      step(); pick_b1 = 0;
      settle(); chk("R4 pick 2B", a_bus, 12'h222);
      step(); pick_b1 = 1;
      settle(); chk("R4 pick back", a_bus, 12'h111);
      step(); a_dis_n = 1;
   endtask

   task automatic t_fwd_1b();
      step();
      b1_dis_n = 0; cap_a1 = 1; a_drv = 12'h3C3;
      settle(); chk("R5 follow", b1_bus, 12'h3C3);
      step(); a_drv = 12'hC3C;
      settle(); chk("R5 follow2", b1_bus, 12'hC3C);
      step(); cap_a1 = 0;
      step(); a_drv = 12'h000;
      settle(); chk("R5 hold", b1_bus, 12'hC3C);
      step(); b1_dis_n = 1;
   endtask

   task automatic t_fwd_indep();
      step();
      b1_dis_n = 0; b2_dis_n = 0; cap_a1 = 1; cap_a2 = 1; a_drv = 12'h0AA;
      settle(); chk("R6 both 1B", b1_bus, 12'h0AA); chk("R6 both 2B", b2_bus, 12'h0AA);
      step(); cap_a1 = 0;
      step(); a_drv = 12'h0BB;
      settle(); chk("R6 2B moves", b2_bus, 12'h0BB); chk("R6 1B holds", b1_bus, 12'h0AA);
      step(); cap_a2 = 0;
      step(); cap_a1 = 1; a_drv = 12'h0CC;
      settle(); chk("R6 1B moves", b1_bus, 12'h0CC); chk("R6 2B holds", b2_bus, 12'h0BB);
      step(); cap_a1 = 0; b1_dis_n = 1; b2_dis_n = 1;
   endtask

   task automatic t_oe_combos();
      for (int i = 0; i < 8; i++) begin
         step();
         {a_dis_n, b1_dis_n, b2_dis_n} = 3'(i);
         settle();
         chk("R7 oe", {9'd0, a_oe, b1_oe, b2_oe}, {9'd0, ~3'(i)});
      end
      step(); a_dis_n = 1; b1_dis_n = 1; b2_dis_n = 1;
   endtask

   task automatic t_oe_keeps();
      step(); cap_a1 = 1; a_drv = 12'h321;
      step(); cap_a1 = 0;
      step(); a_drv = 12'h777;
      step(); b1_dis_n = 0;
      settle(); chk("R8 1B kept", b1_bus, 12'h321);
      step(); b1_dis_n = 1; b1_drv = 12'h654; cap_b1 = 1;
      step(); cap_b1 = 0;
      step(); b1_drv = 12'h999; a_dis_n = 0; pick_b1 = 1;
      settle(); chk("R8 A kept", a_bus, 12'h654);
      step(); a_dis_n = 1;
      step(); a_dis_n = 0;
      settle(); chk("R8 A re-enabled", a_bus, 12'h654);
      step(); a_dis_n = 1;
   endtask

   initial begin
      t_init();
      t_ret_1b();
      t_ret_2b();
      t_select();
      t_fwd_1b();
      t_fwd_indep();
      t_oe_combos();
      t_oe_keeps();
      step();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule